// File: doc/BRIEF.md
# Egress Priority Queue Scheduler

This block decides which transmit queue of one switch egress port supplies the next packet. It does two jobs. First, it classifies each arriving packet into a queue from the packet's 2-bit priority. Second, it arbitrates between the queues whenever the transmitter asks for another packet.

The port can run as one queue, as two queues or as four queues. It can serve those queues in strict priority or by weighted fair service. Weighted service uses a 7-bit credit weight for each queue.

Weighted service runs in rounds. Every queue starts a round with credit equal to its weight. Each grant spends one credit. A new round begins when no queue that holds packets has credit left.

The active queue split and the strict/weighted choice are captured only at the start of a round, together with the weights. A reconfiguration therefore never disturbs a round that is in progress. The block keeps no packet storage. The surrounding logic reports which queues hold packets.

Top module: `egress_sched`

## Requirements
- R1: The split mode codes 00 and 11 select a single queue. Every packet is classified to queue 0, and only queue 0 can be granted, whatever the other non-empty flags say.
- R2: Split mode 01 selects two queues, with queue 1 high and queue 0 low. A packet whose priority is greater than or equal to the threshold input goes to queue 1; any other packet goes to queue 0.
- R3: Split mode 10 selects four queues. The packet priority is used directly as the queue index, where index 3 is the highest priority and index 0 the lowest.
- R4: In strict mode, a grant always names the highest-index queue that is non-empty and enabled by the active split mode.
- R5: In weighted mode, a grant names the highest-index enabled non-empty queue whose credit is nonzero, and it spends one credit of that queue. A weight of 0 loads as a credit of 1.
- R6: In any cycle where no enabled non-empty queue has credit, all credits are reloaded from the weight inputs at the next edge. A request seen in such a cycle, while some enabled queue is non-empty, is held and granted one cycle later.
- R7: A queue that is empty or not enabled is skipped and spends no credit. A request made while no enabled queue is non-empty produces no grant and is dropped.
- R8: A grant is a one-cycle pulse on the grant-valid output in the cycle after the request edge. Back-to-back requests give back-to-back grants while credit allows. The grant queue output keeps its value between grants.
- R9: Changes to the split mode, the strict/weighted select and the weights take effect only at a credit reload. The threshold input acts at once.
- R10: After reset, grant-valid and the grant queue are 0. The active mode is single-queue strict, and the credits hold 8, 4, 2 and 1 for queues 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| splitMode | input | 2 | Queue split request: 00/11 one, 01 two, 10 four |
| weightedEn | input | 1 | 1 selects weighted fair service, 0 strict priority |
| weights | input | 4x7 | Packed per-queue weights, element i for queue i |
| twoQThresh | input | 2 | Priority threshold for the high queue in two-queue mode |
| qNonEmpty | input | 4 | Bit i set when queue i holds a packet |
| pktPrio | input | 2 | Priority of the packet being classified |
| classQ | output | 2 | Queue index for the packet being classified |
| nextReq | input | 1 | Transmitter asks for the next packet |
| grantValid | output | 1 | One-cycle grant pulse |
| grantQ | output | 2 | Queue index of the latest grant |

## Verification
The bench builds the block with its default 7-bit weight width and the 8/4/2/1 reset credits. Weights can still be driven at run time, from 0 up to the defaults.

That range reaches several cases:
- full 15-grant weighted rounds;
- zero weights that must behave as 1;
- a single-credit queue, where every other request lands in a reload cycle and must be held.

A behavioural model tracks the credits, the latched configuration and the held request, and is compared on every cycle. Directed scenarios then cover two more cases:
- a change of mode and weights in the middle of a round;
- reserved mode 11.

// File: rtl/eqs_pkg.sv
package eqs_pkg;
  localparam int QCOUNT = 4;
  localparam int QIDX_W = $clog2(QCOUNT);
  localparam int PRIO_W = 2;

  typedef enum logic [1:0] {
    SPLIT_ONE  = 2'b00,
    SPLIT_TWO  = 2'b01,
    SPLIT_FOUR = 2'b10,
    SPLIT_RSVD = 2'b11
  } splitMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic grant;
    logic spend;
  } schedStrobe_t;

  // queues enabled under a split mode
  function automatic logic [QCOUNT-1:0] modeMask(input logic [1:0] mode);
    logic [QCOUNT-1:0] m;
    case (mode)
      SPLIT_TWO:  m = QCOUNT'(2'b11);
      SPLIT_FOUR: m = '1;
      default:    m = QCOUNT'(1'b1);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/eqs_classify.sv
module eqs_classify
  import eqs_pkg::*;
(
  input  logic [1:0]        activeMode,
  input  logic [1:0]        twoQThresh,
  input  logic [PRIO_W-1:0] pktPrio,
  output logic [QIDX_W-1:0] classQ
);
  always_comb begin
    case (activeMode)
      SPLIT_TWO:  classQ = (pktPrio >= twoQThresh) ? QIDX_W'(1) : QIDX_W'(0);
      SPLIT_FOUR: classQ = QIDX_W'(pktPrio);
      default:    classQ = '0;
    endcase
  end
endmodule

// File: rtl/eqs_ctrl.sv
module eqs_ctrl
  import eqs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         nextReq,
  input  logic [1:0]   splitModeIn,
  input  logic         weightedIn,
  input  logic         anyElig,
  input  logic         haveCand,
  output logic [1:0]   activeMode,
  output logic         activeWeighted,
  output schedStrobe_t strobe
);
  logic pendReq;
  logic wantGrant;

  always_comb begin
    wantGrant     = nextReq | pendReq;
    strobe.grant  = wantGrant & haveCand;
    strobe.spend  = wantGrant & haveCand & activeWeighted;
    strobe.reload = ~haveCand;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMode     <= SPLIT_ONE;
      activeWeighted <= 1'b0;
      pendReq        <= 1'b0;
    end else begin
      // a request that meets a reload cycle waits one cycle
      pendReq <= wantGrant & ~haveCand & anyElig;
      if (strobe.reload) begin
        activeMode     <= splitModeIn;
        activeWeighted <= weightedIn;
      end
    end
  end
endmodule

// File: rtl/eqs_datapath.sv
module eqs_datapath
  import eqs_pkg::*;
#(
  parameter int WEIGHT_W = 7,
  parameter logic [QCOUNT-1:0][WEIGHT_W-1:0] RESET_CREDIT = '1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [QCOUNT-1:0][WEIGHT_W-1:0]  weights,
  input  logic [QCOUNT-1:0]                qNonEmpty,
  input  logic [1:0]                       activeMode,
  input  logic                             activeWeighted,
  input  logic [1:0]                       twoQThresh,
  input  logic [PRIO_W-1:0]                pktPrio,
  input  schedStrobe_t                     strobe,
  output logic                             anyElig,
  output logic                             haveCand,
  output logic [QIDX_W-1:0]                classQ,
  output logic                             grantValid,
  output logic [QIDX_W-1:0]                grantQ
);
  logic [QCOUNT-1:0][WEIGHT_W-1:0] credit;
  logic [QCOUNT-1:0]               eligMask;
  logic [QCOUNT-1:0]               readyMask;
  logic [QIDX_W-1:0]               candQ;

  assign eligMask = qNonEmpty & modeMask(activeMode);

  genvar gq;
  generate
    for (gq = 0; gq < QCOUNT; gq++) begin : g_ready
      assign readyMask[gq] = eligMask[gq] & (~activeWeighted | (credit[gq] != '0));
    end
  endgenerate

  // highest ready index wins
  always_comb begin
    candQ = '0;
    for (int q = 0; q < QCOUNT; q++) begin
      if (readyMask[q]) candQ = QIDX_W'(q);
    end
  end

  assign anyElig  = |eligMask;
  assign haveCand = |readyMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      credit <= RESET_CREDIT;
    end else if (strobe.reload) begin
      for (int q = 0; q < QCOUNT; q++) begin
        credit[q] <= (weights[q] == '0) ? WEIGHT_W'(1) : weights[q];
      end
    end else if (strobe.spend) begin
      credit[candQ] <= credit[candQ] - WEIGHT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantQ     <= '0;
    end else begin
      grantValid <= strobe.grant;
      if (strobe.grant) grantQ <= candQ;
    end
  end

  eqs_classify u_classify (
    .activeMode (activeMode),
    .twoQThresh (twoQThresh),
    .pktPrio    (pktPrio),
    .classQ     (classQ)
  );
endmodule

// File: rtl/egress_sched.sv
module egress_sched
  import eqs_pkg::*;
#(
  parameter int WEIGHT_W = 7,
  parameter logic [QCOUNT-1:0][WEIGHT_W-1:0] RESET_CREDIT =
    {WEIGHT_W'(8), WEIGHT_W'(4), WEIGHT_W'(2), WEIGHT_W'(1)}
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [1:0]                      splitMode,
  input  logic                            weightedEn,
  input  logic [QCOUNT-1:0][WEIGHT_W-1:0] weights,
  input  logic [1:0]                      twoQThresh,
  input  logic [QCOUNT-1:0]               qNonEmpty,
  input  logic [PRIO_W-1:0]               pktPrio,
  output logic [QIDX_W-1:0]               classQ,
  input  logic                            nextReq,
  output logic                            grantValid,
  output logic [QIDX_W-1:0]               grantQ
);
  logic [1:0]   activeMode;
  logic         activeWeighted;
  logic         anyElig;
  logic         haveCand;
  schedStrobe_t strobe;

  eqs_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .nextReq        (nextReq),
    .splitModeIn    (splitMode),
    .weightedIn     (weightedEn),
    .anyElig        (anyElig),
    .haveCand       (haveCand),
    .activeMode     (activeMode),
    .activeWeighted (activeWeighted),
    .strobe         (strobe)
  );

  eqs_datapath #(
    .WEIGHT_W     (WEIGHT_W),
    .RESET_CREDIT (RESET_CREDIT)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .weights        (weights),
    .qNonEmpty      (qNonEmpty),
    .activeMode     (activeMode),
    .activeWeighted (activeWeighted),
    .twoQThresh     (twoQThresh),
    .pktPrio        (pktPrio),
    .strobe         (strobe),
    .anyElig        (anyElig),
    .haveCand       (haveCand),
    .classQ         (classQ),
    .grantValid     (grantValid),
    .grantQ         (grantQ)
  );
endmodule

// File: rtl/eqs_checker.sv
module eqs_checker
  import eqs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              nextReq,
  input logic [QCOUNT-1:0] qNonEmpty,
  input logic [PRIO_W-1:0] pktPrio,
  input logic [1:0]        twoQThresh,
  input logic [QIDX_W-1:0] classQ,
  input logic              grantValid,
  input logic [QIDX_W-1:0] grantQ,
  input logic [1:0]        activeMode,
  input logic              activeWeighted,
  input logic              cfgReload
);
  logic [QCOUNT-1:0] prevElig;
  logic              prevStrict;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevElig   <= '0;
      prevStrict <= 1'b1;
    end else begin
      prevElig   <= qNonEmpty & modeMask(activeMode);
      prevStrict <= ~activeWeighted;
    end
  end

  AST_SINGLE_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode == 2'b00 || activeMode == 2'b11) |-> classQ == '0); // R1
  AST_TWO_Q_THRESH: assert property (@(posedge clk) disable iff (!rstN)
    activeMode == 2'b01 |-> classQ == QIDX_W'(pktPrio >= twoQThresh)); // R2
  AST_FOUR_Q_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    activeMode == 2'b10 |-> classQ == QIDX_W'(pktPrio)); // R3
  AST_STRICT_HIGHEST: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && prevStrict) |-> ((prevElig >> grantQ) >> 1) == '0); // R4
  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> prevElig[grantQ]); // R7
  AST_GRANT_ASKED: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ($past(nextReq) || $past(nextReq, 2))); // R8
  AST_CFG_AT_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeMode) |-> $past(cfgReload)); // R9
endmodule

bind egress_sched eqs_checker u_eqsChecker (
  .clk            (clk),
  .rstN           (rstN),
  .nextReq        (nextReq),
  .qNonEmpty      (qNonEmpty),
  .pktPrio        (pktPrio),
  .twoQThresh     (twoQThresh),
  .classQ         (classQ),
  .grantValid     (grantValid),
  .grantQ         (grantQ),
  .activeMode     (activeMode),
  .activeWeighted (activeWeighted),
  .cfgReload      (strobe.reload)
);

// File: tb/tb_egress_sched.sv
module tb_egress_sched;
  import eqs_pkg::*;
  localparam int WW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]              splitMode;
  logic                    weightedEn;
  logic [QCOUNT-1:0][WW-1:0] weights;
  logic [1:0]              twoQThresh;
  logic [QCOUNT-1:0]       qNonEmpty;
  logic [1:0]              pktPrio;
  logic                    nextReq;
  logic [1:0]              classQ;
  logic                    grantValid;
  logic [1:0]              grantQ;

  egress_sched #(.WEIGHT_W(WW)) dut (
    .clk(clk), .rstN(rstN), .splitMode(splitMode), .weightedEn(weightedEn),
    .weights(weights), .twoQThresh(twoQThresh), .qNonEmpty(qNonEmpty),
    .pktPrio(pktPrio), .classQ(classQ), .nextReq(nextReq),
    .grantValid(grantValid), .grantQ(grantQ)
  );

  int checks = 0;
  int fails = 0;
  int gCount[4];

  // behavioural reference state
  int mMode = 0, mW = 0, mPend = 0;
  int mCred[4] = '{1, 2, 4, 8};
  int eGv = 0, eGq = 0, eFromPend = 0, eWeighted = 0;

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic int expClass();
    if (mMode == 1) return (int'(pktPrio) >= int'(twoQThresh)) ? 1 : 0;
    if (mMode == 2) return int'(pktPrio);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mW = 0; mPend = 0;
      mCred = '{1, 2, 4, 8};
      eGv = 0; eGq = 0; eFromPend = 0;
    end else begin
      int cand;
      int want;
      int anyE;
      bit en[4];
      cand = -1;
      anyE = 0;
      for (int i = 0; i < 4; i++) begin
        en[i] = (i == 0) || (mMode == 1 && i == 1) || (mMode == 2);
        if (en[i] && qNonEmpty[i]) anyE = 1;
      end
      for (int i = 3; i >= 0; i--) begin
        if (cand < 0 && en[i] && qNonEmpty[i] && (mW == 0 || mCred[i] > 0)) cand = i;
      end
      want = (nextReq || mPend != 0) ? 1 : 0;
      eGv = 0;
      if (cand >= 0) begin
        if (want != 0) begin
          eGv = 1; eGq = cand; eWeighted = mW;
          eFromPend = (!nextReq) ? 1 : 0;
          if (mW != 0) mCred[cand] = mCred[cand] - 1;
        end
        mPend = 0;
      end else begin
        mPend = (want != 0 && anyE != 0) ? 1 : 0;
        for (int i = 0; i < 4; i++) mCred[i] = (weights[i] == 0) ? 1 : int'(weights[i]);
        mMode = (splitMode == 2'b01) ? 1 : (splitMode == 2'b10) ? 2 : 0;
        mW = weightedEn ? 1 : 0;
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (rstN) begin
      checkEq(eFromPend != 0 ? "R6" : "R8", "grantValid", int'(grantValid), eGv);
      if (eGv != 0) checkEq(eWeighted != 0 ? "R5" : "R4", "grantQ", int'(grantQ), eGq);
      checkEq(mMode == 1 ? "R2" : (mMode == 2 ? "R3" : "R1"), "classQ", int'(classQ), expClass());
      if (grantValid) gCount[grantQ]++;
    end
  end

  task automatic clearCounts();
    for (int i = 0; i < 4; i++) gCount[i] = 0;
  endtask

  task automatic setCfg(input logic [1:0] md, input logic w, input logic [1:0] thr);
    @(negedge clk);
    qNonEmpty = '0; nextReq = 1'b0;
    splitMode = md; weightedEn = w; twoQThresh = thr;
    repeat (2) @(negedge clk);
  endtask

  task automatic spacedReq(input int n);
    for (int i = 0; i < n; i++) begin
      nextReq = 1'b1;
      @(negedge clk);
      nextReq = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic defaultWeights();
    weights[3] = WW'(8); weights[2] = WW'(4); weights[1] = WW'(2); weights[0] = WW'(1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    splitMode = 2'b10; weightedEn = 1'b1; defaultWeights();
    twoQThresh = 2'd2; qNonEmpty = '0; pktPrio = 2'd3; nextReq = 1'b0;
    clearCounts();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checkEq("R10", "reset grantValid", int'(grantValid), 0);
    checkEq("R10", "reset grantQ", int'(grantQ), 0);
    checkEq("R10", "reset classQ single mode", int'(classQ), 0);

    // R1: reserved mode behaves as single queue
    setCfg(2'b11, 1'b0, 2'd0);
    qNonEmpty = 4'b1000; pktPrio = 2'd3; clearCounts();
    spacedReq(2);
    checkEq("R1", "grants with only q3 busy", gCount[0] + gCount[1] + gCount[2] + gCount[3], 0);
    checkEq("R1", "classQ prio3", int'(classQ), 0);
    qNonEmpty = 4'b1001; clearCounts();
    spacedReq(1);
    checkEq("R1", "q0 grants", gCount[0], 1);

    // R2: two queues with threshold
    setCfg(2'b01, 1'b0, 2'd2);
    pktPrio = 2'd1; #1 checkEq("R2", "prio1 thr2", int'(classQ), 0);
    pktPrio = 2'd2; #1 checkEq("R2", "prio2 thr2", int'(classQ), 1);
    twoQThresh = 2'd0; pktPrio = 2'd0; #1 checkEq("R2", "prio0 thr0", int'(classQ), 1);
    qNonEmpty = 4'b1011; clearCounts();
    spacedReq(2);
    checkEq("R2", "high queue grants", gCount[1], 2);
    checkEq("R2", "q3 outside split", gCount[3], 0);

    // R3 and R4: four queues strict
    setCfg(2'b10, 1'b0, 2'd0);
    for (int p = 0; p < 4; p++) begin
      pktPrio = 2'(p);
      #1 checkEq("R3", "direct class", int'(classQ), p);
    end
    qNonEmpty = 4'b1111; clearCounts();
    spacedReq(4);
    checkEq("R4", "strict q3", gCount[3], 4);
    qNonEmpty = 4'b0101; clearCounts();
    spacedReq(3);
    checkEq("R4", "strict q2", gCount[2], 3);

    // R5: weighted full round
    setCfg(2'b10, 1'b1, 2'd0);
    qNonEmpty = 4'b1111; clearCounts();
    spacedReq(15);
    checkEq("R5", "q3 share", gCount[3], 8);
    checkEq("R5", "q2 share", gCount[2], 4);
    checkEq("R5", "q1 share", gCount[1], 2);
    checkEq("R5", "q0 share", gCount[0], 1);

    // R5: zero weights act as one
    weights = '0;
    setCfg(2'b10, 1'b1, 2'd0);
    qNonEmpty = 4'b1111; clearCounts();
    spacedReq(4);
    for (int i = 0; i < 4; i++) checkEq("R5", "zero weight share", gCount[i], 1);

    // R7: empty queue skipped
    defaultWeights();
    setCfg(2'b10, 1'b1, 2'd0);
    qNonEmpty = 4'b0111; clearCounts();
    spacedReq(7);
    checkEq("R7", "empty q3", gCount[3], 0);
    checkEq("R7", "q2 share", gCount[2], 4);
    checkEq("R7", "q0 share", gCount[0], 1);
    qNonEmpty = '0; clearCounts();
    spacedReq(3);
    checkEq("R7", "no grant when idle", gCount[0] + gCount[1] + gCount[2] + gCount[3], 0);

    // R6: single credit queue, back-to-back requests meet reloads
    weights[0] = WW'(1);
    setCfg(2'b00, 1'b1, 2'd0);
    qNonEmpty = 4'b0001; clearCounts();
    nextReq = 1'b1;
    repeat (3) @(negedge clk);
    nextReq = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R6", "grants over reload", gCount[0], 2);

    // R9: mid-round change waits for reload
    defaultWeights();
    setCfg(2'b10, 1'b1, 2'd0);
    qNonEmpty = 4'b1111; clearCounts();
    spacedReq(1);
    weights[3] = WW'(1); splitMode = 2'b00; pktPrio = 2'd3;
    #1 checkEq("R9", "mode held", int'(classQ), 3);
    spacedReq(7);
    checkEq("R9", "old credit kept", gCount[3], 8);
    spacedReq(1);
    checkEq("R9", "then q2", gCount[2], 1);

    // R8: back-to-back grants
    defaultWeights();
    setCfg(2'b10, 1'b0, 2'd0);
    qNonEmpty = 4'b1111; clearCounts();
    nextReq = 1'b1;
    repeat (5) @(negedge clk);
    nextReq = 1'b0;
    repeat (3) @(negedge clk);
    checkEq("R8", "back-to-back grants", gCount[3], 5);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule